// File: doc/BRIEF.md
# Short Stroke Vector Sequencer

The sequencer accepts one 32-bit command word that packs four 8-bit stroke codes and turns each code into a short straight vector. Each vector runs in one of eight directions spaced 45 degrees apart, starting from a current-position register. A drawn stroke produces one pixel beat per step on a valid/ready output stream. Each beat carries the coordinate and a write-enable flag. A move-only stroke shifts the current position in a single cycle and produces no beats. Codes are taken from the lowest byte upward. A zero code, or a code whose length is zero, is skipped. To run a single stroke, software places it in the top byte and leaves the lower bytes at zero.

Software loads the start position while the block is idle and writes the command word with a valid/ready handshake. It then collects pixel beats until `done` pulses. The draw mode is captured with the command word. The mode can clear the write-enable of the first pixel, the last pixel, or both, on every drawn stroke.

The controller is a four-state machine:
- IDLE waits for a command. On `cmd_valid` (transition *accept*) it goes to PICK.
- PICK examines the code in the current slot.
  - A drawable code takes the *launch* transition to DRAW.
  - A move-only, zero or zero-length code is handled in that one cycle. The machine then takes *next-slot* back to PICK, or *finish* to DONE after the last slot.
- DRAW emits one beat per accepted handshake. After the stroke's last beat it takes *next-slot* or *finish*.
- DONE raises `done` for one cycle and takes *retire* back to IDLE.

Top module: `stroke_seq`

## Requirements
- R1: After reset, `busy`, `done` and `px_valid` are 0, `cmd_ready` is 1 and the current position is (0,0).
- R2: The command word holds slot 0 in bits 7:0, slot 1 in bits 15:8, slot 2 in bits 23:16 and slot 3 in bits 31:24. Slots run in increasing order.
- R3: Within a code, bits 3:0 give the length N (0..15), bit 4 the draw flag and bits 7:5 the direction d. The step for each d is:
  - d=0: (+1,0)
  - d=1: (+1,+1)
  - d=2: (0,+1)
  - d=3: (-1,+1)
  - d=4: (-1,0)
  - d=5: (-1,-1)
  - d=6: (0,-1)
  - d=7: (+1,-1)
- R4: A drawn stroke with N>0 from position P emits exactly N beats at P, P+s, ..., P+(N-1)s, where s is the step of R3. It leaves the position at P+N·s.
- R5: A move-only stroke (draw flag 0, N>0) emits no beat and leaves the position at P+N·s.
- R6: A code equal to zero, or any code with N=0, emits no beat and leaves the position unchanged.
- R7: The draw mode (`draw_mode`) is captured when the command is accepted. Its effect on `px_we` is:
  - mode 0: every beat of a drawn stroke has `px_we`=1.
  - mode 1: the first beat has `px_we`=0.
  - mode 2: the last beat has `px_we`=0.
  - mode 3: both the first and the last beat have `px_we`=0.
- R8: While `px_valid` is 1 and `px_ready` is 0, `px_valid`, `px_x`, `px_y` and `px_we` hold their values.
- R9: `cmd_ready` is 0 while `busy` is 1. A `pos_load` pulse is applied only while `cmd_ready` is 1 and is ignored otherwise.
- R10: `done` is a one-cycle pulse, after the last slot has completed. In that cycle `busy` is 0 and the position is final.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Sequencer idle, command accepted this cycle if offered |
| cmd_word | input | 32 | Four packed stroke codes |
| draw_mode | input | 2 | Endpoint suppression mode, captured with the command |
| pos_load | input | 1 | Load the current position (idle only) |
| pos_x_in | input | 16 | X value for `pos_load` |
| pos_y_in | input | 16 | Y value for `pos_load` |
| cur_x | output | 16 | Current X position |
| cur_y | output | 16 | Current Y position |
| px_valid | output | 1 | Pixel beat available |
| px_ready | input | 1 | Consumer accepts the beat |
| px_x | output | 16 | Beat X coordinate |
| px_y | output | 16 | Beat Y coordinate |
| px_we | output | 1 | Beat is to be written |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps every direction, every length from 0 to 15, both draw-flag settings and all four draw modes in the top slot. It then runs a few hundred random words in which individual bytes are zeroed, to exercise slot order and skipped codes.

Each sweep targets a specific class of error:
- A swapped or mis-signed diagonal would put beats on the wrong octant.
- An off-by-one step counter would give N±1 beats or a wrong final position.
- A move-only stroke that stepped per pixel would still pass on position but is caught by the absence of beats.

Randomized backpressure checks that a stalled beat does not advance the position or lose a pixel. A `pos_load` pulse issued mid-command must leave the final position untouched.

// File: rtl/stroke_pkg.sv
package stroke_pkg;

    localparam int DIR_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PICK,
        ST_DRAW,
        ST_DONE
    } seq_state_t;

    // X step of a direction code, two's complement: 01 = +1, 11 = -1
    function automatic logic [1:0] dir_step_x(input logic [DIR_W-1:0] d);
        logic [1:0] r;
        unique case (d)
            3'd0, 3'd1, 3'd7: r = 2'b01;
            3'd3, 3'd4, 3'd5: r = 2'b11;
            default:          r = 2'b00;
        endcase
        return r;
    endfunction

    function automatic logic [1:0] dir_step_y(input logic [DIR_W-1:0] d);
        logic [1:0] r;
        unique case (d)
            3'd1, 3'd2, 3'd3: r = 2'b01;
            3'd5, 3'd6, 3'd7: r = 2'b11;
            default:          r = 2'b00;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/stroke_decode.sv
module stroke_decode
    import stroke_pkg::*;
#(
    parameter int LEN_W  = 4,
    localparam int CODE_W = LEN_W + 1 + DIR_W
) (
    input  logic [CODE_W-1:0] code,
    output logic [LEN_W-1:0]  len,
    output logic              act,
    output logic [1:0]        step_x,
    output logic [1:0]        step_y,
    output logic              is_null
);

    logic [DIR_W-1:0] dir;

    always_comb begin
        len     = code[LEN_W-1:0];
        act     = code[LEN_W];
        dir     = code[CODE_W-1 -: DIR_W];
        step_x  = dir_step_x(dir);
        step_y  = dir_step_y(dir);
        // zero code and zero-length code both have len == 0
        is_null = (len == '0);
    end

endmodule

// File: rtl/pos_accum.sv
module pos_accum #(
    parameter int POS_W = 16,
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [POS_W-1:0] ld_x,
    input  logic [POS_W-1:0] ld_y,
    input  logic             adv,
    input  logic             jump,
    input  logic [1:0]       step_x,
    input  logic [1:0]       step_y,
    input  logic [LEN_W-1:0] len,
    output logic [POS_W-1:0] cur_x,
    output logic [POS_W-1:0] cur_y
);

    logic [POS_W-1:0] amt;
    logic [POS_W-1:0] dlt_x;
    logic [POS_W-1:0] dlt_y;

    always_comb begin
        amt = jump ? {{(POS_W-LEN_W){1'b0}}, len} : POS_W'(1);
        unique case (step_x)
            2'b01:   dlt_x = amt;
            2'b11:   dlt_x = -amt;
            default: dlt_x = '0;
        endcase
        unique case (step_y)
            2'b01:   dlt_y = amt;
            2'b11:   dlt_y = -amt;
            default: dlt_y = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_x <= '0;
            cur_y <= '0;
        end else if (load) begin
            cur_x <= ld_x;
            cur_y <= ld_y;
        end else if (adv || jump) begin
            cur_x <= cur_x + dlt_x;
            cur_y <= cur_y + dlt_y;
        end
    end

    // a stalled or idle cycle must not move the position
    p_pos_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv && !jump) |=> ($stable(cur_x) && $stable(cur_y)));

endmodule

// File: rtl/stroke_fsm.sv
module stroke_fsm
    import stroke_pkg::*;
#(
    parameter int N_STROKES = 4,
    parameter int LEN_W     = 4,
    localparam int CODE_W = LEN_W + 1 + DIR_W,
    localparam int WORD_W = N_STROKES * CODE_W,
    localparam int SLOT_W = (N_STROKES > 1) ? $clog2(N_STROKES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic [1:0]        draw_mode,
    output logic              cmd_ready,
    output logic [CODE_W-1:0] code,
    input  logic [LEN_W-1:0]  len,
    input  logic              act,
    input  logic              is_null,
    input  logic              px_ready,
    output logic              px_valid,
    output logic              px_we,
    output logic              adv,
    output logic              jump,
    output logic              busy,
    output logic              done
);

    seq_state_t        state, state_nx;
    logic [WORD_W-1:0] word_q;
    logic [1:0]        mode_q;
    logic [SLOT_W-1:0] slot;
    logic [LEN_W-1:0]  step;
    logic              last_slot;
    logic              first_px;
    logic              last_px;
    logic              launch;

    always_comb begin
        code      = word_q[slot*CODE_W +: CODE_W];
        last_slot = (slot == SLOT_W'(N_STROKES-1));
        first_px  = (step == '0);
        last_px   = (step == (len - LEN_W'(1)));
        launch    = !is_null && act;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (cmd_valid) state_nx = ST_PICK;
            ST_PICK: begin
                if (launch)         state_nx = ST_DRAW;
                else if (last_slot) state_nx = ST_DONE;
            end
            ST_DRAW: begin
                if (px_ready && last_px)
                    state_nx = last_slot ? ST_DONE : ST_PICK;
            end
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // slot and step counters, command capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            mode_q <= '0;
            slot   <= '0;
            step   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (cmd_valid) begin
                    word_q <= cmd_word;
                    mode_q <= draw_mode;
                    slot   <= '0;
                    step   <= '0;
                end
                ST_PICK: begin
                    if (launch)          step <= '0;
                    else if (!last_slot) slot <= slot + SLOT_W'(1);
                end
                ST_DRAW: if (px_ready) begin
                    if (last_px) begin
                        step <= '0;
                        if (!last_slot) slot <= slot + SLOT_W'(1);
                    end else begin
                        step <= step + LEN_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        cmd_ready = (state == ST_IDLE);
        busy      = (state == ST_PICK) || (state == ST_DRAW);
        done      = (state == ST_DONE);
        px_valid  = (state == ST_DRAW);
        px_we     = (state == ST_DRAW)
                    && !(mode_q[0] && first_px)
                    && !(mode_q[1] && last_px);
        adv       = (state == ST_DRAW) && px_ready;
        jump      = (state == ST_PICK) && !is_null && !act;
    end

    p_ready_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cmd_ready);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_done_after_work_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    p_beat_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid |-> busy);

    p_beat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (px_valid && !px_ready) |=> (px_valid && $stable(px_we)));

endmodule

// File: rtl/stroke_seq.sv
module stroke_seq
    import stroke_pkg::*;
#(
    parameter int POS_W     = 16,
    parameter int LEN_W     = 4,
    parameter int N_STROKES = 4,
    localparam int CODE_W = LEN_W + 1 + DIR_W,
    localparam int WORD_W = N_STROKES * CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic [1:0]        draw_mode,
    input  logic              pos_load,
    input  logic [POS_W-1:0]  pos_x_in,
    input  logic [POS_W-1:0]  pos_y_in,
    output logic [POS_W-1:0]  cur_x,
    output logic [POS_W-1:0]  cur_y,
    output logic              px_valid,
    input  logic              px_ready,
    output logic [POS_W-1:0]  px_x,
    output logic [POS_W-1:0]  px_y,
    output logic              px_we,
    output logic              busy,
    output logic              done
);

    logic [CODE_W-1:0] code;
    logic [LEN_W-1:0]  len;
    logic              act;
    logic [1:0]        step_x;
    logic [1:0]        step_y;
    logic              is_null;
    logic              adv;
    logic              jump;
    logic              load_ok;

    stroke_fsm #(.N_STROKES(N_STROKES), .LEN_W(LEN_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .draw_mode (draw_mode),
        .cmd_ready (cmd_ready),
        .code      (code),
        .len       (len),
        .act       (act),
        .is_null   (is_null),
        .px_ready  (px_ready),
        .px_valid  (px_valid),
        .px_we     (px_we),
        .adv       (adv),
        .jump      (jump),
        .busy      (busy),
        .done      (done)
    );

    stroke_decode #(.LEN_W(LEN_W)) u_dec (
        .code    (code),
        .len     (len),
        .act     (act),
        .step_x  (step_x),
        .step_y  (step_y),
        .is_null (is_null)
    );

    assign load_ok = pos_load && cmd_ready;

    pos_accum #(.POS_W(POS_W), .LEN_W(LEN_W)) u_pos (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load_ok),
        .ld_x   (pos_x_in),
        .ld_y   (pos_y_in),
        .adv    (adv),
        .jump   (jump),
        .step_x (step_x),
        .step_y (step_y),
        .len    (len),
        .cur_x  (cur_x),
        .cur_y  (cur_y)
    );

    assign px_x = cur_x;
    assign px_y = cur_y;

    p_coord_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (px_valid && !px_ready) |=> ($stable(px_x) && $stable(px_y)));

    p_unit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (px_valid && px_ready) |=>
            (((cur_x - $past(cur_x)) == POS_W'(0)) ||
             ((cur_x - $past(cur_x)) == POS_W'(1)) ||
             ((cur_x - $past(cur_x)) == {POS_W{1'b1}})));

endmodule

// File: tb/stroke_seq_tb.sv
module stroke_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_word = '0;
    logic [1:0]  draw_mode = '0;
    logic        pos_load = 1'b0;
    logic [15:0] pos_x_in = '0;
    logic [15:0] pos_y_in = '0;
    logic [15:0] cur_x, cur_y, px_x, px_y;
    logic        px_valid, px_we, busy, done;
    logic        px_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [15:0] lf = 16'hACE1;

    always #5 clk = ~clk;

    stroke_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_word(cmd_word), .draw_mode(draw_mode), .pos_load(pos_load),
        .pos_x_in(pos_x_in), .pos_y_in(pos_y_in), .cur_x(cur_x), .cur_y(cur_y),
        .px_valid(px_valid), .px_ready(px_ready), .px_x(px_x), .px_y(px_y),
        .px_we(px_we), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic lf_step();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    endtask

    function automatic int ref_dx(input int d);
        if (d == 0 || d == 1 || d == 7) return 1;
        if (d >= 3 && d <= 5) return -1;
        return 0;
    endfunction

    function automatic int ref_dy(input int d);
        if (d >= 1 && d <= 3) return 1;
        if (d >= 5) return -1;
        return 0;
    endfunction

    // run one command word and check every beat and the final position
    task automatic run_word(input logic [31:0] w, input logic [1:0] m, input bit stall,
                            input int sx, input int sy, input bit poke,
                            input string btag, input string ftag);
        int ex, ey;
        ex = sx; ey = sy;
        @(negedge clk);
        pos_load = 1'b1; pos_x_in = 16'(sx); pos_y_in = 16'(sy);
        @(negedge clk);
        pos_load = 1'b0;
        chk(cmd_ready == 1'b1, "R9 idle ready", int'(cmd_ready), 1);
        cmd_valid = 1'b1; cmd_word = w; draw_mode = m;
        @(negedge clk);
        cmd_valid = 1'b0;
        draw_mode = ~m;                          // must be ignored: captured at accept (R7)
        chk(cmd_ready == 1'b0 && busy == 1'b1, "R9 ready while busy", int'(cmd_ready), 0);
        pos_load = poke; pos_x_in = 16'd1234; pos_y_in = 16'd4321;
        @(negedge clk);
        pos_load = 1'b0;
        for (int s = 0; s < 4; s++) begin
            int c, n, a, d;
            c = int'(w[s*8 +: 8]);
            n = c & 15; a = (c >> 4) & 1; d = (c >> 5) & 7;
            if (n == 0) continue;
            if (a == 0) begin
                ex += n * ref_dx(d); ey += n * ref_dy(d);
                continue;
            end
            for (int k = 0; k < n; k++) begin
                bit got;
                got = 1'b0;
                for (int t = 0; t < 100 && !got; t++) begin
                    logic r;
                    r = stall ? lf[0] : 1'b1;
                    lf_step();
                    px_ready = r;
                    if (px_valid && r) begin
                        bit wexp;
                        wexp = !((m[0] && k == 0) || (m[1] && k == n - 1));
                        chk(int'($signed(px_x)) == ex, {btag, " beat x"}, int'($signed(px_x)), ex);
                        chk(int'($signed(px_y)) == ey, {btag, " beat y"}, int'($signed(px_y)), ey);
                        chk(px_we == wexp, "R7 write enable", int'(px_we), int'(wexp));
                        got = 1'b1;
                    end
                    @(negedge clk);
                end
                if (!got) chk(1'b0, {btag, " beat missing"}, 0, 1);
                ex += ref_dx(d); ey += ref_dy(d);
            end
        end
        px_ready = 1'b1;
        begin
            bit seen;
            seen = 1'b0;
            for (int t = 0; t < 20 && !seen; t++) begin
                if (done) seen = 1'b1;
                else begin
                    if (px_valid) chk(1'b0, {ftag, " extra beat"}, 1, 0);
                    @(negedge clk);
                end
            end
            chk(seen, "R10 done pulse", int'(seen), 1);
            chk(busy == 1'b0, "R10 busy at done", int'(busy), 0);
            chk(int'($signed(cur_x)) == ex, {ftag, " final x"}, int'($signed(cur_x)), ex);
            chk(int'($signed(cur_y)) == ey, {ftag, " final y"}, int'($signed(cur_y)), ey);
        end
        px_ready = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R10 done one cycle", int'(done), 0);
    endtask

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0 && done == 1'b0, "R1 busy/done", int'({busy, done}), 0);
        chk(px_valid == 1'b0, "R1 px_valid", int'(px_valid), 0);
        chk(cmd_ready == 1'b1, "R1 cmd_ready", int'(cmd_ready), 1);
        chk(cur_x == 16'd0 && cur_y == 16'd0, "R1 position", int'(cur_x) + int'(cur_y), 0);

        // R3 R4 R5 R6 R7: one stroke in the top slot, every direction, length, flag, mode
        for (int d = 0; d < 8; d++)
            for (int n = 0; n < 16; n++)
                for (int a = 0; a < 2; a++)
                    for (int m = 0; m < 4; m++) begin
                        logic [7:0] c;
                        bit st;
                        c = 8'((d << 5) | (a << 4) | n);
                        st = ((n + d + m) % 2) == 1;
                        run_word({c, 24'h0}, 2'(m), st, 200, -300, 1'b0,
                                 st ? "R8" : "R3",
                                 (n == 0) ? "R6" : (a == 1) ? "R4" : "R5");
                    end

        // R6: empty word leaves position alone
        run_word(32'h0, 2'd0, 1'b0, -17, 42, 1'b0, "R6", "R6");

        // R9: position load while busy is ignored
        run_word(32'hF5F5_F5F5, 2'd0, 1'b1, 10, 20, 1'b1, "R9", "R9");

        // R2: random words with random zeroed bytes, exercising slot order
        for (int i = 0; i < 300; i++) begin
            logic [31:0] w;
            logic [1:0]  m;
            bit st;
            for (int b = 0; b < 4; b++) begin
                w[b*8 +: 8] = lf[7:0];
                lf_step();
                if (lf[1:0] == 2'b00) w[b*8 +: 8] = 8'h00;
                lf_step();
            end
            m = lf[3:2];
            st = lf[4];
            lf_step();
            run_word(w, m, st, -100 + i, 150 - i, 1'b0, "R2", "R2");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule